// File: doc/BRIEF.md
# Banked Cache-Line Fetch Engine

This engine fills one cache line of four words from a main-memory model whose timing is fixed and counter-based. A caller presents a line address with a request strobe. While the engine is idle it takes the address and spends a known number of cycles in three kinds of work. It sends the address, waits for the storage access, and moves words across the bus. It then hands the words back to the cache and reports how many cycles the fill took.

The memory organisation is chosen at elaboration by a parameter, and there are three choices. A single one-word memory repeats the access and transfer for every word. A memory four words wide performs one access and delivers the line in one transfer. Four one-word banks receive one shared address and read in parallel; they then return their words on consecutive cycles. Storage contents are not held anywhere. Each word is a fixed function of its address.

Top module: `line_fetch_engine`

## Requirements
- R1: When `req_valid` is high in a cycle where `busy` is low, the address is taken at that clock edge, and `busy` is high from the next cycle.
- R2: With the one-word memory (organisation 0), busy cycles are numbered from 1. Word k is strobed on `word_valid` in busy cycle 1+16(k+1), which is cycles 17, 33, 49 and 65. The fill lasts 65 cycles.
- R3: With the four-word memory (organisation 1), `line_valid` pulses once, in busy cycle 17, and `word_valid` never rises. At that pulse `line_data` carries word 0 in bits 31:0 and word 3 in bits 127:96. The fill lasts 17 cycles.
- R4: With the banked memory (organisation 2), words 0 to 3 are strobed in busy cycles 17, 18, 19 and 20. The fill lasts 20 cycles.
- R5: Words arrive in ascending offset order, and `word_idx` gives the offset at each strobe. `word_valid` and `line_valid` are never high together, and neither is high outside a fill.
- R6: Word k of line address A has the value ((4A+k) * 0x00010003) XOR 0x5A5AC3C3, computed modulo 2^32.
- R7: `fill_done` is high in exactly the last busy cycle, which is also the last transfer cycle. `busy` is low in the cycle after it.
- R8: `penalty_cycles` reads 0 in the first busy cycle and rises by one in each busy cycle. After the fill it holds the full fill length (65, 17 or 20) until the next request is accepted.
- R9: A request made while `busy` is high is ignored. This includes the `fill_done` cycle. The fill in progress keeps its timing and its data, and no second fill starts from that request.
- R10: After reset `busy`, `word_valid`, `line_valid` and `fill_done` are low and `penalty_cycles` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Fill request |
| req_line_addr | input | ADDR_W (16) | Line address of the request |
| busy | output | 1 | Fill in progress |
| word_valid | output | 1 | One word delivered this cycle (organisations 0 and 2) |
| word_idx | output | IDX_W (2) | Offset of the delivered word |
| word_data | output | WORD_W (32) | Delivered word |
| line_valid | output | 1 | Whole line delivered this cycle (organisation 1) |
| line_data | output | LINE_WORDS*WORD_W (128) | Whole line, word 0 in the low bits |
| fill_done | output | 1 | Last transfer cycle of the fill |
| penalty_cycles | output | PEN_W (8) | Running count of fill cycles, then the measured penalty |

## Verification
The assertions check, on every cycle, several rules that hold at any time. Strobes are exclusive and occur only inside a fill, and in wide mode no single word is ever strobed. `fill_done` falls inside the fill and is followed by idle. The captured address cannot change during a fill. The counter resets on acceptance, ends at the organisation's penalty, and holds while idle.

Some properties depend on the exact cycle of each strobe, on word values, and on requests that arrive during a fill. Of these, the done-cycle request and back-to-back requests are cases only the bench scenarios can show. The bench compares its behavioural timeline against all three organisations, cycle by cycle.

// File: rtl/lfe_pkg.sv
package lfe_pkg;

  typedef enum logic [1:0] {
    ORG_NARROW = 2'd0,
    ORG_WIDE   = 2'd1,
    ORG_BANKED = 2'd2
  } mem_org_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ADDR   = 2'd1,
    PH_ACCESS = 2'd2,
    PH_XFER   = 2'd3
  } fill_phase_e;

  // Total cycles of one line fill for a given organisation.
  function automatic int unsigned fill_penalty(mem_org_e org, int unsigned words,
                                               int unsigned t_addr, int unsigned t_acc,
                                               int unsigned t_xfer);
    case (org)
      ORG_NARROW: return t_addr + words * (t_acc + t_xfer);
      ORG_WIDE:   return t_addr + t_acc + t_xfer;
      default:    return t_addr + t_acc + words * t_xfer;
    endcase
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Content model of the backing storage: a word is a function of its address.
  function automatic logic [31:0] dram_word(logic [31:0] line_addr, int unsigned off,
                                            int unsigned words);
    logic [31:0] waddr;
    waddr = line_addr * words + off;
    return (waddr * 32'h0001_0003) ^ 32'h5A5A_C3C3;
  endfunction

endpackage

// File: rtl/lfe_sequencer.sv
module lfe_sequencer
  import lfe_pkg::*;
#(
  parameter mem_org_e    MEM_ORG    = ORG_BANKED,
  parameter int unsigned LINE_WORDS = 4,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned ADDR_CYC   = 1,
  parameter int unsigned ACCESS_CYC = 15,
  parameter int unsigned XFER_CYC   = 1,
  localparam int unsigned IDX_W     = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1,
  localparam int unsigned MAXT      = max3(ADDR_CYC, ACCESS_CYC, XFER_CYC),
  localparam int unsigned PC_W      = $clog2(MAXT + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_line_addr,
  output logic              busy,
  output logic              accept,
  output logic              access_done,
  output logic              beat_strobe,
  output logic              fill_end,
  output logic [IDX_W-1:0]  beat_idx,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam logic [PC_W-1:0]  PC_ADDR   = PC_W'(ADDR_CYC - 1);
  localparam logic [PC_W-1:0]  PC_ACCESS = PC_W'(ACCESS_CYC - 1);
  localparam logic [PC_W-1:0]  PC_XFER   = PC_W'(XFER_CYC - 1);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(LINE_WORDS - 1);

  fill_phase_e      phase;
  logic [PC_W-1:0]  pc;
  logic             last_beat;
  logic             pc_zero;

  always_comb begin
    pc_zero     = (pc == '0);
    busy        = (phase != PH_IDLE);
    accept      = (phase == PH_IDLE) && req_valid;
    access_done = (phase == PH_ACCESS) && pc_zero;
    beat_strobe = (phase == PH_XFER) && pc_zero;
    last_beat   = (MEM_ORG == ORG_WIDE) ? 1'b1 : (beat_idx == LAST_IDX);
    fill_end    = beat_strobe && last_beat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      pc       <= '0;
      beat_idx <= '0;
      cur_addr <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            cur_addr <= req_line_addr;
            beat_idx <= '0;
            pc       <= PC_ADDR;
            phase    <= PH_ADDR;
          end
        end
        PH_ADDR: begin
          if (pc_zero) begin
            phase <= PH_ACCESS;
            pc    <= PC_ACCESS;
          end else begin
            pc <= pc - PC_W'(1);
          end
        end
        PH_ACCESS: begin
          if (pc_zero) begin
            phase <= PH_XFER;
            pc    <= PC_XFER;
          end else begin
            pc <= pc - PC_W'(1);
          end
        end
        default: begin
          if (!pc_zero) begin
            pc <= pc - PC_W'(1);
          end else if (last_beat) begin
            phase <= PH_IDLE;
          end else begin
            beat_idx <= beat_idx + IDX_W'(1);
            if (MEM_ORG == ORG_NARROW) begin
              phase <= PH_ACCESS;
              pc    <= PC_ACCESS;
            end else begin
              pc <= PC_XFER;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/lfe_bank_array.sv
module lfe_bank_array
  import lfe_pkg::*;
#(
  parameter mem_org_e    MEM_ORG    = ORG_BANKED,
  parameter int unsigned LINE_WORDS = 4,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned ADDR_W     = 16,
  localparam int unsigned IDX_W     = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1,
  localparam int unsigned LANES     = (MEM_ORG == ORG_NARROW) ? 1 : LINE_WORDS
)(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               access_done,
  input  logic [ADDR_W-1:0]                  cur_addr,
  input  logic [IDX_W-1:0]                   beat_idx,
  output logic [LINE_WORDS-1:0][WORD_W-1:0]  lane_data
);

  for (genvar g = 0; g < LINE_WORDS; g++) begin : g_lane
    if (g < LANES) begin : g_bank
      logic [IDX_W-1:0] off;
      logic [WORD_W-1:0] q;
      assign off = (MEM_ORG == ORG_NARROW) ? beat_idx : IDX_W'(g);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (access_done) begin
          q <= WORD_W'(dram_word(32'(cur_addr), int'(off), LINE_WORDS));
        end
      end
      assign lane_data[g] = q;
    end else begin : g_none
      assign lane_data[g] = '0;
    end
  end

endmodule

// File: rtl/lfe_penalty_ctr.sv
module lfe_penalty_ctr #(
  parameter int unsigned PEN_W = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             busy,
  output logic [PEN_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (accept) begin
      count <= '0;
    end else if (busy) begin
      count <= count + PEN_W'(1);
    end
  end

endmodule

// File: rtl/line_fetch_engine.sv
module line_fetch_engine
  import lfe_pkg::*;
#(
  parameter mem_org_e    MEM_ORG    = ORG_BANKED,
  parameter int unsigned LINE_WORDS = 4,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned ADDR_CYC   = 1,
  parameter int unsigned ACCESS_CYC = 15,
  parameter int unsigned XFER_CYC   = 1,
  parameter int unsigned PEN_W      = 8,
  localparam int unsigned IDX_W     = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [ADDR_W-1:0]            req_line_addr,
  output logic                         busy,
  output logic                         word_valid,
  output logic [IDX_W-1:0]             word_idx,
  output logic [WORD_W-1:0]            word_data,
  output logic                         line_valid,
  output logic [LINE_WORDS*WORD_W-1:0] line_data,
  output logic                         fill_done,
  output logic [PEN_W-1:0]             penalty_cycles
);

  // Named internal events, visible to the bound checker.
  logic                              accept;
  logic                              access_done;
  logic                              beat_strobe;
  logic                              fill_end;
  logic [IDX_W-1:0]                  beat_idx;
  logic [ADDR_W-1:0]                 cur_addr;
  logic [LINE_WORDS-1:0][WORD_W-1:0] lane_data;
  logic [WORD_W-1:0]                 sel_word;

  lfe_sequencer #(
    .MEM_ORG(MEM_ORG), .LINE_WORDS(LINE_WORDS), .ADDR_W(ADDR_W),
    .ADDR_CYC(ADDR_CYC), .ACCESS_CYC(ACCESS_CYC), .XFER_CYC(XFER_CYC)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line_addr(req_line_addr),
    .busy(busy), .accept(accept), .access_done(access_done),
    .beat_strobe(beat_strobe), .fill_end(fill_end), .beat_idx(beat_idx),
    .cur_addr(cur_addr)
  );

  lfe_bank_array #(
    .MEM_ORG(MEM_ORG), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
  ) banks_i (
    .clk(clk), .rst_n(rst_n), .access_done(access_done), .cur_addr(cur_addr),
    .beat_idx(beat_idx), .lane_data(lane_data)
  );

  lfe_penalty_ctr #(.PEN_W(PEN_W)) pen_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy), .count(penalty_cycles)
  );

  assign sel_word = (MEM_ORG == ORG_NARROW) ? lane_data[0] : lane_data[beat_idx];

  always_comb begin
    word_valid = beat_strobe && (MEM_ORG != ORG_WIDE);
    line_valid = beat_strobe && (MEM_ORG == ORG_WIDE);
    word_idx   = beat_idx;
    word_data  = word_valid ? sel_word : '0;
    line_data  = line_valid ? lane_data : '0;
    fill_done  = fill_end;
  end

endmodule

// File: rtl/lfe_checker.sv
module lfe_checker
  import lfe_pkg::*;
#(
  parameter mem_org_e    MEM_ORG    = ORG_BANKED,
  parameter int unsigned LINE_WORDS = 4,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned ADDR_CYC   = 1,
  parameter int unsigned ACCESS_CYC = 15,
  parameter int unsigned XFER_CYC   = 1,
  parameter int unsigned PEN_W      = 8
)(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              accept,
  input logic              word_valid,
  input logic              line_valid,
  input logic              fill_done,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [PEN_W-1:0]  penalty_cycles
);

  localparam int unsigned FILL =
    fill_penalty(MEM_ORG, LINE_WORDS, ADDR_CYC, ACCESS_CYC, XFER_CYC);

  initial assert_penalty_fits_R8: assert (FILL < (1 << PEN_W));

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && (penalty_cycles == '0));

  assert_wide_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (MEM_ORG == ORG_WIDE) |-> !word_valid);

  assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({word_valid, line_valid}));

  assert_strobe_in_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid || line_valid) |-> busy);

  assert_done_in_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> busy);

  assert_idle_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !busy);

  assert_final_penalty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (penalty_cycles == PEN_W'(FILL)));

  assert_penalty_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid) |=> $stable(penalty_cycles));

  assert_addr_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cur_addr));

endmodule

bind line_fetch_engine lfe_checker #(
  .MEM_ORG(MEM_ORG), .LINE_WORDS(LINE_WORDS), .ADDR_W(ADDR_W),
  .ADDR_CYC(ADDR_CYC), .ACCESS_CYC(ACCESS_CYC), .XFER_CYC(XFER_CYC), .PEN_W(PEN_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .accept(accept),
  .word_valid(word_valid), .line_valid(line_valid), .fill_done(fill_done),
  .cur_addr(cur_addr), .penalty_cycles(penalty_cycles)
);

// File: tb/line_fetch_engine_tb_top.sv
module line_fetch_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TA = 1;
  localparam int TC = 15;
  localparam int TX = 1;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [15:0] addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic         busy_a  [3];
  logic         wv_a    [3];
  logic [1:0]   idx_a   [3];
  logic [31:0]  wd_a    [3];
  logic         lv_a    [3];
  logic [127:0] ld_a    [3];
  logic         done_a  [3];
  logic [7:0]   pen_a   [3];

  line_fetch_engine #(.MEM_ORG(lfe_pkg::ORG_NARROW)) dut_nar_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req), .req_line_addr(addr),
    .busy(busy_a[0]), .word_valid(wv_a[0]), .word_idx(idx_a[0]), .word_data(wd_a[0]),
    .line_valid(lv_a[0]), .line_data(ld_a[0]), .fill_done(done_a[0]),
    .penalty_cycles(pen_a[0]));

  line_fetch_engine #(.MEM_ORG(lfe_pkg::ORG_WIDE)) dut_wide_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req), .req_line_addr(addr),
    .busy(busy_a[1]), .word_valid(wv_a[1]), .word_idx(idx_a[1]), .word_data(wd_a[1]),
    .line_valid(lv_a[1]), .line_data(ld_a[1]), .fill_done(done_a[1]),
    .penalty_cycles(pen_a[1]));

  line_fetch_engine #(.MEM_ORG(lfe_pkg::ORG_BANKED)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req), .req_line_addr(addr),
    .busy(busy_a[2]), .word_valid(wv_a[2]), .word_idx(idx_a[2]), .word_data(wd_a[2]),
    .line_valid(lv_a[2]), .line_data(ld_a[2]), .fill_done(done_a[2]),
    .penalty_cycles(pen_a[2]));

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Behavioural model state per organisation: position in the fill, latched line, count.
  int          t    [3];
  int          pen  [3];
  logic [15:0] la   [3];
  bit          ign  [3];

  function automatic int fill_len(int o);
    if (o == 0) return 65;
    if (o == 1) return 17;
    return 20;
  endfunction

  function automatic int strobe_at(int o, int k);
    if (o == 0) return TA + (k + 1) * (TC + TX);
    if (o == 1) return TA + TC + TX;
    return TA + TC + (k + 1) * TX;
  endfunction

  function automatic logic [31:0] ref_word(logic [15:0] a, int k);
    logic [31:0] w;
    w = {16'd0, a} * 32'd4 + 32'(k);
    return (w * 32'd65539) ^ 32'h5A5AC3C3;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int o = 0; o < 3; o++) begin
      bit   e_busy, e_wv, e_lv, e_done;
      int   e_k;
      string tt;
      logic [127:0] e_line;
      tt = (o == 0) ? "R2" : (o == 1) ? "R3" : "R4";
      e_busy = (t[o] > 0);
      e_done = (t[o] == fill_len(o));
      e_wv = 0; e_k = 0;
      e_lv = (o == 1) && e_done;
      if (o != 1) begin
        for (int k = 0; k < 4; k++) begin
          if (t[o] == strobe_at(o, k)) begin
            e_wv = 1; e_k = k;
          end
        end
      end
      check(busy_a[o] == e_busy, ign[o] ? "R9" : "R1", "busy", 128'(busy_a[o]), 128'(e_busy));
      check(done_a[o] == e_done, "R7", "fill_done", 128'(done_a[o]), 128'(e_done));
      check(wv_a[o] == e_wv, tt, "word_valid", 128'(wv_a[o]), 128'(e_wv));
      check(lv_a[o] == e_lv, tt, "line_valid", 128'(lv_a[o]), 128'(e_lv));
      check(pen_a[o] == 8'(pen[o]), "R8", "penalty", 128'(pen_a[o]), 128'(pen[o]));
      if (e_wv) begin
        check(idx_a[o] == 2'(e_k), "R5", "word_idx", 128'(idx_a[o]), 128'(e_k));
        check(wd_a[o] == ref_word(la[o], e_k), ign[o] ? "R9" : "R6", "word_data",
              128'(wd_a[o]), 128'(ref_word(la[o], e_k)));
      end
      if (e_lv) begin
        e_line = {ref_word(la[o], 3), ref_word(la[o], 2), ref_word(la[o], 1), ref_word(la[o], 0)};
        check(ld_a[o] == e_line, ign[o] ? "R9" : "R3", "line_data", ld_a[o], e_line);
      end
    end
  endtask

  // One cycle: check at the falling edge, drive inputs, advance the model past the next rising edge.
  task automatic cyc(bit r, logic [15:0] a);
    @(negedge clk);
    if (finished) return;
    compare_all();
    req  = r;
    addr = a;
    for (int o = 0; o < 3; o++) begin
      if (t[o] == 0) begin
        if (r) begin
          t[o] = 1; pen[o] = 0; la[o] = a; ign[o] = 0;
        end
      end else begin
        pen[o] = t[o];
        if (r) ign[o] = 1;
        t[o] = (t[o] == fill_len(o)) ? 0 : t[o] + 1;
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'h0);
  endtask

  task automatic summary();
    finished = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    for (int o = 0; o < 3; o++) begin
      t[o] = 0; pen[o] = 0; la[o] = '0; ign[o] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    for (int o = 0; o < 3; o++) begin
      check(!busy_a[o] && !wv_a[o] && !lv_a[o] && !done_a[o], "R10", "strobes/busy",
            128'({busy_a[o], wv_a[o], lv_a[o], done_a[o]}), 128'(0));
      check(pen_a[o] == 8'd0, "R10", "penalty", 128'(pen_a[o]), 128'(0));
    end
    rst_n = 1'b1;
    idle(2);
    // single fill from line 0 (R1, R2, R3, R4, R6)
    cyc(1'b1, 16'h0000);
    idle(70);
    // R9: requests hammered during a fill are ignored by the fill in progress
    cyc(1'b1, 16'h1234);
    for (int i = 0; i < 30; i++) cyc(1'b1, 16'h4000 + 16'(i));
    idle(70);
    // back-to-back: request held high, including in done cycles (R7, R8, R9)
    for (int i = 0; i < 150; i++) cyc(1'b1, 16'h8000 ^ 16'(i * 7));
    idle(70);
    // top of the address range
    cyc(1'b1, 16'hFFFF);
    idle(70);
    cyc(1'b1, 16'hA5C3);
    idle(70);
    summary();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

endmodule